// File: doc/BRIEF.md
# Asynchronous Serial Character Transmitter

This block turns one parallel character at a time into an asynchronous serial frame on a single output line. Pacing comes from an external enable pulse that arrives at sixteen times the bit rate. A character is offered on a valid/ready handshake. Once it is taken, the line carries a low start bit, then the data bits with the least significant first, then an optional parity bit, then a high stop period. The line rests high between frames.

The character format is chosen per character and is captured when the character is accepted. The options are the number of data bits (five to eight), parity (none, even or odd) and a short or long stop period. A break input pulls the line low at any time without disturbing the frame timing underneath. An empty flag reports when the shifter has nothing left to send. A caller can hold a new character ready during the final stop tick, and it then follows back-to-back with no idle gap.

Top module: `uart_tx_serializer`

## Requirements
- R1: After reset and while idle, `txLine` is 1, `txEmpty` is 1 and `inReady` is 1.
- R2: A character is taken on a clock edge where `inValid` and `inReady` are both 1. While a frame is in progress, `inReady` is 0 except during the cycle holding the final baud tick of the stop period.
- R3: A frame begins with a start bit of value 0. Then come the data bits, least significant first. Their count is 5 + `charLen`: 00→5, 01→6, 10→7, 11→8. Unused upper bits of `inData` are never sent.
- R4: When `parityEn` is 1, one parity bit follows the data. With `parityOdd` = 0 it makes the number of ones among the data and parity bits even. With `parityOdd` = 1 it makes that number odd. When `parityEn` is 0, no parity bit is sent.
- R5: The stop period drives the line to 1. It lasts 16 ticks when `stopLong` = 0. With `stopLong` = 1 it lasts 24 ticks if `charLen` = 00 and 32 ticks otherwise.
- R6: Every start, data and parity bit lasts exactly 16 `baudTick` pulses. Without `baudTick` pulses the frame does not advance.
- R7: While `breakCtl` is 1, `txLine` is 0. Frame sequencing continues underneath, so the frame ends on the same cycle as it would without break.
- R8: `txEmpty` falls on the edge that accepts a character. It rises only on the edge that ends the stop period, and only if no new character is taken on that edge. A character taken on that edge starts its start bit at once.
- R9: `charLen`, `parityEn`, `parityOdd` and `stopLong` are sampled at acceptance. Changing them during a frame does not alter that frame's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| baudTick | input | 1 | One-cycle enable at 16x the bit rate |
| inData | input | DATA_W | Character to send |
| inValid | input | 1 | Character offered |
| inReady | output | 1 | Character can be taken this cycle |
| charLen | input | 2 | Data bit count minus five |
| parityEn | input | 1 | Append a parity bit |
| parityOdd | input | 1 | 1 = odd parity, 0 = even |
| stopLong | input | 1 | 0 = one stop bit, 1 = 1.5 (5-bit) or 2 stop bits |
| breakCtl | input | 1 | Force the line low |
| txLine | output | 1 | Serial output |
| txEmpty | output | 1 | Shifter idle, nothing pending |

## Verification
The bench builds the block with its defaults: DATA_W = 8 and OVERSAMPLE = 16. With these values every character length from five to eight bits can be reached, and so can all three stop lengths, including the 24-tick half-bit case. Most tests drive `baudTick` high on every cycle, so each bit lasts exactly 16 clocks and bit centres and frame ends land on predictable cycles. One test withholds ticks to show that the frame stalls. Other directed tests place break, mid-frame format changes and a back-to-back hand-over on exact cycles.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  // which source drives the serial line
  typedef enum logic [1:0] {
    LINE_MARK  = 2'd0,
    LINE_START = 2'd1,
    LINE_DATA  = 2'd2,
    LINE_PAR   = 2'd3
  } lineSel_t;

  // control to datapath strobes
  typedef struct packed {
    logic     load;
    logic     shift;
    lineSel_t sel;
  } txStrobes_t;
endpackage

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl
  import uart_tx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       baudTick,
  input  logic       inValid,
  input  logic [1:0] charLen,
  input  logic       parityEn,
  input  logic       stopLong,
  output logic       inReady,
  output logic       txEmpty,
  output txStrobes_t strb
);
  localparam int TW   = $clog2(2 * OVERSAMPLE);
  localparam int BW   = $clog2(DATA_W);
  localparam int HALF = OVERSAMPLE / 2;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} state_t;

  state_t        state;
  logic [TW-1:0] tickCnt;
  logic [TW-1:0] lastTick;
  logic [BW-1:0] bitCnt;
  logic [1:0]    lenReg;
  logic          parReg;
  logic          stopReg;
  logic          bitEnd;
  logic          lastData;
  logic          accept;

  always_comb begin
    if (state != S_STOP || !stopReg) lastTick = TW'(OVERSAMPLE - 1);
    else if (lenReg == 2'd0)          lastTick = TW'(OVERSAMPLE + HALF - 1);
    else                              lastTick = TW'(2 * OVERSAMPLE - 1);
  end

  assign bitEnd   = baudTick && (tickCnt == lastTick);
  assign lastData = (bitCnt == BW'(DATA_W - 4) + BW'(lenReg));
  assign inReady  = (state == S_IDLE) || (state == S_STOP && bitEnd);
  assign accept   = inValid && inReady;
  assign txEmpty  = (state == S_IDLE);

  always_comb begin
    strb.load  = accept;
    strb.shift = (state == S_DATA) && bitEnd;
    case (state)
      S_START: strb.sel = LINE_START;
      S_DATA:  strb.sel = LINE_DATA;
      S_PAR:   strb.sel = LINE_PAR;
      default: strb.sel = LINE_MARK;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      tickCnt <= '0;
      bitCnt  <= '0;
      lenReg  <= '0;
      parReg  <= 1'b0;
      stopReg <= 1'b0;
    end else begin
      if (accept) begin
        lenReg  <= charLen;
        parReg  <= parityEn;
        stopReg <= stopLong;
      end
      if (state != S_IDLE && baudTick)
        tickCnt <= bitEnd ? '0 : tickCnt + 1'b1;
      case (state)
        S_IDLE: if (accept) begin
          state   <= S_START;
          tickCnt <= '0;
        end
        S_START: if (bitEnd) begin
          state  <= S_DATA;
          bitCnt <= '0;
        end
        S_DATA: if (bitEnd) begin
          if (lastData) state <= parReg ? S_PAR : S_STOP;
          else          bitCnt <= bitCnt + 1'b1;
        end
        S_PAR: if (bitEnd) state <= S_STOP;
        S_STOP: if (bitEnd) state <= accept ? S_START : S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_tx_datapath.sv
module uart_tx_datapath
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobes_t        strb,
  input  logic [DATA_W-1:0] inData,
  input  logic [1:0]        charLen,
  input  logic              parityOdd,
  input  logic              breakCtl,
  output logic              txLine
);
  localparam int MIN_BITS = DATA_W - 3;

  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] lenMask;
  logic              parBit;

  always_comb begin
    for (int i = 0; i < DATA_W; i++)
      lenMask[i] = (i < MIN_BITS + int'(charLen));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      parBit   <= 1'b0;
    end else if (strb.load) begin
      shiftReg <= inData;
      parBit   <= (^(inData & lenMask)) ^ parityOdd;
    end else if (strb.shift) begin
      shiftReg <= shiftReg >> 1;
    end
  end

  always_comb begin
    if (breakCtl) txLine = 1'b0;
    else begin
      case (strb.sel)
        LINE_START: txLine = 1'b0;
        LINE_DATA:  txLine = shiftReg[0];
        LINE_PAR:   txLine = parBit;
        default:    txLine = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/uart_tx_serializer.sv
module uart_tx_serializer
  import uart_tx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baudTick,
  input  logic [DATA_W-1:0] inData,
  input  logic              inValid,
  output logic              inReady,
  input  logic [1:0]        charLen,
  input  logic              parityEn,
  input  logic              parityOdd,
  input  logic              stopLong,
  input  logic              breakCtl,
  output logic              txLine,
  output logic              txEmpty
);
  txStrobes_t strb;

  uart_tx_ctrl #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) ctrl_i (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .inValid(inValid),
    .charLen(charLen), .parityEn(parityEn), .stopLong(stopLong),
    .inReady(inReady), .txEmpty(txEmpty), .strb(strb)
  );

  uart_tx_datapath #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .inData(inData),
    .charLen(charLen), .parityOdd(parityOdd), .breakCtl(breakCtl),
    .txLine(txLine)
  );
endmodule

// File: rtl/uart_tx_serializer_chk.sv
module uart_tx_serializer_chk (
  input logic clk,
  input logic rstN,
  input logic baudTick,
  input logic inValid,
  input logic inReady,
  input logic breakCtl,
  input logic txLine,
  input logic txEmpty
);
  // R1
  idle_mark_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txEmpty && !breakCtl) |-> txLine);

  // R2
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!txEmpty && !baudTick) |-> !inReady);

  // R8
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> !txEmpty);

  // R7
  break_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    breakCtl |-> !txLine);

  // R6
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!baudTick && !txEmpty && !inValid) |=> !txEmpty);
endmodule

bind uart_tx_serializer uart_tx_serializer_chk chk_i (
  .clk(clk), .rstN(rstN), .baudTick(baudTick), .inValid(inValid),
  .inReady(inReady), .breakCtl(breakCtl), .txLine(txLine), .txEmpty(txEmpty)
);

// File: tb/uart_tx_serializer_tb.sv
module uart_tx_serializer_tb_top;
  localparam int CLK_P = 10;

  typedef struct packed {
    logic [7:0] d;
    logic [1:0] len;
    logic       pe;
    logic       po;
    logic       sl;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{8'hA5, 2'd3, 1'b0, 1'b0, 1'b0},
    '{8'h3C, 2'd3, 1'b1, 1'b0, 1'b0},
    '{8'h3D, 2'd3, 1'b1, 1'b1, 1'b1},
    '{8'hFB, 2'd0, 1'b1, 1'b0, 1'b1},
    '{8'hF6, 2'd1, 1'b1, 1'b1, 1'b0},
    '{8'h55, 2'd2, 1'b0, 1'b0, 1'b1}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic baudTick = 1'b1;
  logic [7:0] inData = '0;
  logic inValid = 1'b0;
  logic inReady;
  logic [1:0] charLen = '0;
  logic parityEn = 1'b0, parityOdd = 1'b0, stopLong = 1'b0, breakCtl = 1'b0;
  logic txLine, txEmpty;

  int cyc = 0;
  int checks = 0;
  int failures = 0;
  int acceptCyc = 0;
  bit done = 1'b0;

  always #(CLK_P / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  uart_tx_serializer dut_i (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .inData(inData),
    .inValid(inValid), .inReady(inReady), .charLen(charLen),
    .parityEn(parityEn), .parityOdd(parityOdd), .stopLong(stopLong),
    .breakCtl(breakCtl), .txLine(txLine), .txEmpty(txEmpty)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  task automatic waitTo(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  function automatic int nBits(input logic [1:0] len);
    return 5 + int'(len);
  endfunction

  function automatic int stopTicks(input logic [1:0] len, input logic sl);
    if (!sl) return 16;
    return (len == 2'd0) ? 24 : 32;
  endfunction

  function automatic int frameLen(input vec_t v);
    return 16 * (1 + nBits(v.len) + int'(v.pe)) + stopTicks(v.len, v.sl);
  endfunction

  function automatic logic expParity(input vec_t v);
    logic p = v.po;
    for (int i = 0; i < nBits(v.len); i++) p ^= v.d[i];
    return p;
  endfunction

  // called at a negedge with the block idle; returns at negedge after accept
  task automatic send(input vec_t v);
    inData = v.d; charLen = v.len; parityEn = v.pe;
    parityOdd = v.po; stopLong = v.sl; inValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    acceptCyc = cyc;
    inValid = 1'b0;
  endtask

  task automatic checkFrame(input vec_t v, input string tag);
    int nb = nBits(v.len);
    int last = nb + int'(v.pe);
    int endC = acceptCyc + frameLen(v);
    for (int k = 0; k <= last; k++) begin
      waitTo(acceptCyc + 8 + 16 * k);
      if (k == 0) begin
        check({tag, " R3 start bit"}, txLine, 0);
        check({tag, " R2 ready low busy"}, inReady, 0);
      end else if (k <= nb)
        check({tag, " R3 data bit"}, txLine, v.d[k-1]);
      else
        check({tag, " R4 parity bit"}, txLine, expParity(v));
    end
    waitTo(acceptCyc + 16 * (last + 1) + 8);
    check({tag, " R5 stop level"}, txLine, 1);
    waitTo(endC - 1);
    check({tag, " R5 stop not ended"}, txEmpty, 0);
    waitTo(endC);
    check({tag, " R8 empty after stop"}, txEmpty, 1);
  endtask

  initial begin
    vec_t v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 line idle", txLine, 1);
    check("R1 empty idle", txEmpty, 1);
    check("R1 ready idle", inReady, 1);

    // table walk: R3 R4 R5 R6
    for (int i = 0; i < 6; i++) begin
      send(VECS[i]);
      check("R8 empty falls", txEmpty, 0);
      checkFrame(VECS[i], $sformatf("vec%0d", i));
    end

    // R7 break mid-frame, timing unchanged
    v = '{8'hB3, 2'd3, 1'b0, 1'b0, 1'b0};
    send(v);
    waitTo(acceptCyc + 8 + 32);
    breakCtl = 1'b1; #1;
    check("R7 break forces low", txLine, 0);
    waitTo(acceptCyc + 8 + 64);
    breakCtl = 1'b0; #1;
    check("R7 sequence continued", txLine, v.d[3]);
    waitTo(acceptCyc + frameLen(v) - 1);
    check("R7 end timing busy", txEmpty, 0);
    waitTo(acceptCyc + frameLen(v));
    check("R7 end timing idle", txEmpty, 1);

    // R6 no ticks, no progress
    v = '{8'h0F, 2'd3, 1'b0, 1'b0, 1'b0};
    send(v);
    waitTo(acceptCyc + 4);
    baudTick = 1'b0;
    waitTo(acceptCyc + 44);
    check("R6 stalled in start", txLine, 0);
    check("R6 stalled busy", txEmpty, 0);
    baudTick = 1'b1;
    waitTo(acceptCyc + 40 + frameLen(v) - 1);
    check("R6 stretched end busy", txEmpty, 0);
    waitTo(acceptCyc + 40 + frameLen(v));
    check("R6 stretched end idle", txEmpty, 1);

    // R9 format change mid-frame ignored
    v = '{8'h12, 2'd0, 1'b0, 1'b0, 1'b0};
    send(v);
    waitTo(acceptCyc + 20);
    charLen = 2'd3; stopLong = 1'b1; parityEn = 1'b1;
    waitTo(acceptCyc + frameLen(v) - 1);
    check("R9 length kept busy", txEmpty, 0);
    waitTo(acceptCyc + frameLen(v));
    check("R9 length kept idle", txEmpty, 1);

    // R8 back-to-back hand-over
    v = '{8'h09, 2'd0, 1'b0, 1'b0, 1'b0};
    send(v);
    inValid = 1'b1; inData = 8'h6A; charLen = 2'd3; parityEn = 1'b0; stopLong = 1'b0;
    waitTo(acceptCyc + frameLen(v) - 1);
    check("R2 ready on last stop tick", inReady, 1);
    check("R8 busy on last stop tick", txEmpty, 0);
    waitTo(acceptCyc + frameLen(v));
    inValid = 1'b0;
    check("R8 no empty between frames", txEmpty, 0);
    check("R8 new start at once", txLine, 0);
    acceptCyc = acceptCyc + frameLen(v);
    checkFrame('{8'h6A, 2'd3, 1'b0, 1'b0, 1'b0}, "b2b");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule